// File: doc/BRIEF.md
# Soft-Interrupt and Tick-Compare Unit

This block is the privileged timer and software-interrupt register set beside a processor core. It keeps a free-running 63-bit tick counter with a trap flag. The trap flag blocks unprivileged reads of the counter. The block also holds a 16-bit soft-interrupt pending register and a compare register. The compare register has a disable bit. When the armed compare value equals the counter, bit 0 of the pending register is set. The block always presents the highest pending interrupt level. It pulses a check signal when a software write raises that level.

Software reaches the registers through a flat single-cycle port: an address, read and write strobes, 64-bit write data and a privilege input. Read data and the fault code are combinational in the cycle of the strobe. Register effects land at the next rising edge. Two extra write-only addresses set or clear pending bits without a read-modify-write.

The compare logic is a two-state machine. CMP_IDLE means no match can fire. CMP_ARMED means a match fires when the counter equals the compare value. The machine moves from CMP_IDLE to CMP_ARMED on an arming write: a privileged compare write with the disable bit clear and a value above the current count. It moves from CMP_ARMED to CMP_IDLE on a match (fire), or on a compare write that does not arm (disarm). A compare write that arms again while in CMP_ARMED stays in CMP_ARMED (re-arm).

Top module: `tick_softint_unit`

## Requirements
- R1: Address 1 writes the pending register directly (bits 15:0 of the data). A write to address 2 ORs the data into it. A write to address 3 clears every bit that is set in the data. Each result is visible in the cycle after the write. Address 1 reads return the register zero-extended.
- R2: Fault codes are 0 none, 1 privileged-opcode, 2 privileged-action and 3 illegal. When `priv` is low, any access to addresses 1 to 4 and any write to address 0 report code 1, change nothing and read as zero.
- R3: Address 4 holds the compare register. Bit 63 is the disable bit and bits 62:0 are the compare value. A privileged read returns what was last written.
- R4: A compare write arms a match only when its disable bit is clear and its value is strictly greater than the count in the write cycle. A write that sets the disable bit cancels an armed match. No match fires while the disable bit is set.
- R5: Address 0 reads return the trap flag in bit 63 and the count in bits 62:0. The count advances by one every cycle. A privileged write loads the count from bits 62:0 and the flag from bit 63, and the loaded count is read back in the next cycle.
- R6: An unprivileged read of address 0 while the trap flag is set returns zero with code 2. With the flag clear, the read is served normally with code 0.
- R7: When armed and the count equals the compare value, bit 0 of the pending register is set in the next cycle. The machine then disarms, so the match fires once.
- R8: `irq_level` is the index of the highest set pending bit among bits 15:1. Bit 0 counts as level 14. The output is the larger of the two, and 0 when nothing is pending.
- R9: `irq_check` is high for one cycle, in the cycle after a successful write to addresses 1 to 3, when the level after the write is above the level before it.
- R10: Addresses 5 to 7, and reads of addresses 2 and 3, report code 3, read as zero and change no state.
- R11: After reset the count is 0, the trap flag is 1, the compare register reads 0x8000000000000000 and the pending register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (wins when both strobes are high) |
| wdata | input | 64 | Write data |
| priv | input | 1 | High when the access is privileged |
| rdata | output | 64 | Read data, combinational in the access cycle |
| fault | output | 2 | Fault code of the access in this cycle |
| irq_level | output | 4 | Highest pending interrupt level |
| irq_check | output | 1 | One-cycle pulse after a write that raises the level |

## Verification
`fault` and `rdata` are due in the same cycle as the strobe. The bench drives the strobe at the falling edge and samples these two outputs 1 ns later. Counter, compare and pending-register effects, and the `irq_check` pulse, are due one rising edge after the access. A match adds one more edge: it fires while the count equals the compare value, and bit 0 appears after the next edge. The bench model advances once per rising edge and compares every output on every cycle, so each result is checked in exactly the cycle it is due.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_TICK     = 3'd0;
    localparam logic [ADDR_W-1:0] A_SOFT     = 3'd1;
    localparam logic [ADDR_W-1:0] A_SOFT_SET = 3'd2;
    localparam logic [ADDR_W-1:0] A_SOFT_CLR = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP      = 3'd4;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_PRIV_OP  = 2'd1,
        FLT_PRIV_ACT = 2'd2,
        FLT_ILLEGAL  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SIW_PUT = 2'd0,
        SIW_SET = 2'd1,
        SIW_CLR = 2'd2
    } si_op_e;

    typedef enum logic {
        CMP_IDLE  = 1'b0,
        CMP_ARMED = 1'b1
    } cmp_state_e;
endpackage

// File: rtl/tsu_counter.sv
module tsu_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_flag,
    output logic [CNT_W-1:0] count,
    output logic             trap_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            trap_flag <= 1'b1;
        end else if (load) begin
            count     <= load_val;
            trap_flag <= load_flag;
        end else begin
            count     <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tsu_softint.sv
module tsu_softint
    import tsu_pkg::*;
#(
    parameter int SI_W      = 16,
    parameter int MATCH_LVL = 14,
    parameter int LVL_W     = $clog2(SI_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  si_op_e           op,
    input  logic [SI_W-1:0]  wval,
    input  logic             match_set,
    output logic [SI_W-1:0]  si_q,
    output logic [LVL_W-1:0] level,
    output logic             irq_check
);
    logic [SI_W-1:0] si_next;

    function automatic logic [LVL_W-1:0] lvl_of(input logic [SI_W-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i < SI_W; i++) begin
            if (v[i]) r = LVL_W'(i);
        end
        if (v[0] && (r < LVL_W'(MATCH_LVL))) r = LVL_W'(MATCH_LVL);
        return r;
    endfunction

    always_comb begin
        si_next = si_q;
        if (wr) begin
            unique case (op)
                SIW_PUT: si_next = wval;
                SIW_SET: si_next = si_q | wval;
                SIW_CLR: si_next = si_q & ~wval;
                default: si_next = si_q;
            endcase
        end
        if (match_set) si_next[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            si_q      <= '0;
            irq_check <= 1'b0;
        end else begin
            si_q      <= si_next;
            irq_check <= wr && (lvl_of(si_next) > lvl_of(si_q));
        end
    end

    assign level = lvl_of(si_q);
endmodule

// File: rtl/tsu_cmp.sv
module tsu_cmp
    import tsu_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wval,
    input  logic             wdis,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_val,
    output logic             cmp_dis,
    output logic             match,
    output cmp_state_e       state
);
    cmp_state_e state_nx;
    logic       arm_ok;

    assign arm_ok = !wdis && (wval > count);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CMP_IDLE;
            cmp_val <= '0;
            cmp_dis <= 1'b1;
        end else begin
            state <= state_nx;
            if (wr) begin
                cmp_val <= wval;
                cmp_dis <= wdis;
            end
        end
    end

    // next state and outputs
    always_comb begin
        match    = 1'b0;
        state_nx = state;
        unique case (state)
            CMP_IDLE: begin
                if (wr && arm_ok) state_nx = CMP_ARMED;
            end
            CMP_ARMED: begin
                match = !cmp_dis && (count == cmp_val);
                if (wr)         state_nx = arm_ok ? CMP_ARMED : CMP_IDLE;
                else if (match) state_nx = CMP_IDLE;
            end
            default: state_nx = CMP_IDLE;
        endcase
    end
endmodule

// File: rtl/tick_softint_unit.sv
module tick_softint_unit
    import tsu_pkg::*;
#(
    parameter int CNT_W     = 63,
    parameter int SI_W      = 16,
    parameter int MATCH_LVL = 14,
    parameter int DW        = CNT_W + 1,
    parameter int LVL_W     = $clog2(SI_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic              priv,
    output logic [DW-1:0]     rdata,
    output logic [1:0]        fault,
    output logic [LVL_W-1:0]  irq_level,
    output logic              irq_check
);
    logic [CNT_W-1:0] cnt_q;
    logic             trap_q;
    logic [SI_W-1:0]  si_q;
    logic [CNT_W-1:0] cmp_val_q;
    logic             cmp_dis_q;
    logic             cmp_match;
    cmp_state_e       cmp_state;

    logic             is_wr, is_rd, ok;
    fault_e           flt;
    logic [DW-1:0]    rd_val;
    logic             si_wr, cnt_load, cmp_wr;
    si_op_e           si_op;

    always_comb begin
        is_wr  = wr_en;
        is_rd  = rd_en && !wr_en;
        flt    = FLT_NONE;
        rd_val = '0;
        si_op  = SIW_PUT;
        if (is_wr || is_rd) begin
            case (addr)
                A_TICK: begin
                    if (is_wr && !priv)                flt = FLT_PRIV_OP;
                    else if (is_rd && !priv && trap_q) flt = FLT_PRIV_ACT;
                    else                               rd_val = {trap_q, cnt_q};
                end
                A_SOFT: begin
                    if (!priv) flt = FLT_PRIV_OP;
                    else       rd_val = {{(DW-SI_W){1'b0}}, si_q};
                end
                A_SOFT_SET, A_SOFT_CLR: begin
                    if (is_rd)      flt = FLT_ILLEGAL;
                    else if (!priv) flt = FLT_PRIV_OP;
                    si_op = (addr == A_SOFT_SET) ? SIW_SET : SIW_CLR;
                end
                A_CMP: begin
                    if (!priv) flt = FLT_PRIV_OP;
                    else       rd_val = {cmp_dis_q, cmp_val_q};
                end
                default: flt = FLT_ILLEGAL;
            endcase
        end
        ok       = (is_wr || is_rd) && (flt == FLT_NONE);
        si_wr    = ok && is_wr && (addr == A_SOFT || addr == A_SOFT_SET || addr == A_SOFT_CLR);
        cnt_load = ok && is_wr && (addr == A_TICK);
        cmp_wr   = ok && is_wr && (addr == A_CMP);
    end

    assign fault = flt;
    assign rdata = (ok && is_rd) ? rd_val : '0;

    tsu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (wdata[CNT_W-1:0]),
        .load_flag (wdata[CNT_W]),
        .count     (cnt_q),
        .trap_flag (trap_q)
    );

    tsu_softint #(.SI_W(SI_W), .MATCH_LVL(MATCH_LVL), .LVL_W(LVL_W)) u_si (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (si_wr),
        .op        (si_op),
        .wval      (wdata[SI_W-1:0]),
        .match_set (cmp_match),
        .si_q      (si_q),
        .level     (irq_level),
        .irq_check (irq_check)
    );

    tsu_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cmp_wr),
        .wval    (wdata[CNT_W-1:0]),
        .wdis    (wdata[CNT_W]),
        .count   (cnt_q),
        .cmp_val (cmp_val_q),
        .cmp_dis (cmp_dis_q),
        .match   (cmp_match),
        .state   (cmp_state)
    );
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker
    import tsu_pkg::*;
#(
    parameter int CNT_W = 63,
    parameter int SI_W  = 16,
    parameter int DW    = CNT_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DW-1:0]     rdata,
    input logic [1:0]        fault,
    input logic              irq_check,
    input logic [SI_W-1:0]   si_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cmp_dis_q,
    input logic              cmp_match
);
    p_priv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fault == FLT_PRIV_OP && !cmp_match) |=> $stable(si_q) && $stable(cmp_dis_q));

    p_no_match_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_dis_q |-> !cmp_match);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_TICK && fault == FLT_NONE) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_trap_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == FLT_PRIV_ACT) |-> (rdata == '0 && rd_en && !wr_en));

    p_match_sets_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_match |=> si_q[0]);

    p_check_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_check |-> $past(wr_en));

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == FLT_ILLEGAL && !cmp_match) |=> $stable(si_q) && $stable(cmp_dis_q));

    p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == FLT_ILLEGAL) |-> rdata == '0);
endmodule

bind tick_softint_unit tsu_checker #(.CNT_W(CNT_W), .SI_W(SI_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rdata     (rdata),
    .fault     (fault),
    .irq_check (irq_check),
    .si_q      (si_q),
    .cnt_q     (cnt_q),
    .cmp_dis_q (cmp_dis_q),
    .cmp_match (cmp_match)
);

// File: tb/tick_softint_unit_bench.sv
`timescale 1ns/1ps
module tick_softint_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, priv = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [1:0]  fault;
    logic [3:0]  irq_level;
    logic        irq_check;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model
    logic [62:0] m_cnt;
    logic        m_npt, m_dis, m_armed, m_chk;
    logic [62:0] m_cval;
    logic [15:0] m_si;
    logic [63:0] last_rd;
    logic [1:0]  last_f;

    always #4 clk = ~clk;

    tick_softint_unit u_tick_softint_unit (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .priv(priv), .rdata(rdata), .fault(fault),
        .irq_level(irq_level), .irq_check(irq_check)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] m_level(input logic [15:0] v);
        logic [3:0] r = 4'd0;
        for (int i = 15; i >= 1; i--) begin
            if (v[i]) begin r = 4'(i); break; end
        end
        if (v[0] && r < 4'd14) r = 4'd14;
        return r;
    endfunction

    function automatic logic [1:0] m_fault(input logic r, input logic w, input logic [2:0] a, input logic p);
        if (!r && !w) return 2'd0;
        if (a >= 3'd5) return 2'd3;
        if (!w && (a == 3'd2 || a == 3'd3)) return 2'd3;
        if (a == 3'd0) begin
            if (w && !p) return 2'd1;
            if (!w && !p && m_npt) return 2'd2;
            return 2'd0;
        end
        return p ? 2'd0 : 2'd1;
    endfunction

    task automatic step(input logic r, input logic w, input logic [2:0] a, input logic [63:0] d, input logic p);
        logic [1:0]  ef;
        logic [63:0] er;
        logic        ok, mm, rd;
        logic [15:0] si_n;
        string       ftag;
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wdata = d; priv = p;
        #1;
        rd = r && !w;
        ef = m_fault(r, w, a, p);
        ok = (r || w) && ef == 2'd0;
        er = 64'd0;
        if (ok && rd) begin
            if (a == 3'd0)      er = {m_npt, m_cnt};
            else if (a == 3'd1) er = {48'd0, m_si};
            else                er = {m_dis, m_cval};
        end
        if (ef == 2'd3)       ftag = "R10";
        else if (ef == 2'd2 || (a == 3'd0 && rd)) ftag = "R6";
        else                  ftag = "R2";
        check(ftag, "fault", 64'(fault), 64'(ef));
        check(a == 3'd0 ? "R5" : (a == 3'd4 ? "R3" : "R1"), "rdata", rdata, er);
        check("R8", "irq_level", 64'(irq_level), 64'(m_level(m_si)));
        check("R9", "irq_check", 64'(irq_check), 64'(m_chk));
        last_rd = rdata; last_f = fault;
        // model update for the coming edge
        mm = m_armed && !m_dis && (m_cnt == m_cval);
        si_n = m_si;
        if (ok && w) begin
            if (a == 3'd1) si_n = d[15:0];
            if (a == 3'd2) si_n = m_si | d[15:0];
            if (a == 3'd3) si_n = m_si & ~d[15:0];
        end
        if (mm) si_n[0] = 1'b1;
        @(posedge clk);
        m_chk = ok && w && (a >= 3'd1 && a <= 3'd3) && (m_level(si_n) > m_level(m_si));
        if (ok && w && a == 3'd4) begin
            m_armed = !d[63] && (d[62:0] > m_cnt);
            m_dis = d[63]; m_cval = d[62:0];
        end else if (mm) m_armed = 1'b0;
        m_si = si_n;
        if (ok && w && a == 3'd0) begin m_cnt = d[62:0]; m_npt = d[63]; end
        else m_cnt = m_cnt + 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 64'd0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5313));
        m_cnt = '0; m_npt = 1'b1; m_dis = 1'b1; m_armed = 1'b0; m_chk = 1'b0;
        m_cval = '0; m_si = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); m_cnt = m_cnt + 1'b1;

        // R11 reset state
        step(1'b1, 1'b0, 3'd4, 64'd0, 1'b1);
        check("R11", "compare after reset", last_rd, 64'h8000_0000_0000_0000);
        step(1'b1, 1'b0, 3'd1, 64'd0, 1'b1);
        check("R11", "pending after reset", last_rd, 64'd0);
        step(1'b1, 1'b0, 3'd0, 64'd0, 1'b0);
        check("R6", "trap read fault", 64'(last_f), 64'd2);

        // R5 counter load and trap flag clear
        step(1'b0, 1'b1, 3'd0, {1'b0, 63'd1000}, 1'b1);
        step(1'b1, 1'b0, 3'd0, 64'd0, 1'b0);
        check("R5", "loaded count", last_rd, 64'd1000);

        // R1 direct, set and clear
        step(1'b0, 1'b1, 3'd1, 64'h0010, 1'b1);
        step(1'b0, 1'b1, 3'd2, 64'h0100, 1'b1);
        step(1'b0, 1'b1, 3'd3, 64'h0010, 1'b1);
        step(1'b1, 1'b0, 3'd1, 64'd0, 1'b1);
        check("R1", "set/clear result", last_rd, 64'h0100);
        check("R8", "level of bit 8", 64'(irq_level), 64'd8);

        // R2 unprivileged write ignored
        step(1'b0, 1'b1, 3'd1, 64'hFFFF, 1'b0);
        check("R2", "privileged-opcode fault", 64'(last_f), 64'd1);
        step(1'b1, 1'b0, 3'd1, 64'd0, 1'b1);
        check("R2", "pending unchanged", last_rd, 64'h0100);

        // R4 compare at the current count does not arm
        step(1'b0, 1'b1, 3'd3, 64'hFFFF, 1'b1);
        step(1'b0, 1'b1, 3'd4, {1'b0, m_cnt}, 1'b1);
        idle(30);
        step(1'b1, 1'b0, 3'd1, 64'd0, 1'b1);
        check("R4", "no match when behind", last_rd, 64'd0);

        // R7 armed match fires once
        step(1'b0, 1'b1, 3'd4, {1'b0, m_cnt + 63'd5}, 1'b1);
        idle(10);
        step(1'b1, 1'b0, 3'd1, 64'd0, 1'b1);
        check("R7", "match sets bit 0", last_rd, 64'd1);
        check("R8", "bit 0 level", 64'(irq_level), 64'd14);
        step(1'b0, 1'b1, 3'd3, 64'h1, 1'b1);
        idle(10);
        step(1'b1, 1'b0, 3'd1, 64'd0, 1'b1);
        check("R7", "no second fire", last_rd, 64'd0);

        // R4 disable cancels an armed match
        step(1'b0, 1'b1, 3'd4, {1'b0, m_cnt + 63'd10}, 1'b1);
        step(1'b0, 1'b1, 3'd4, {1'b1, m_cnt + 63'd9}, 1'b1);
        idle(20);
        step(1'b1, 1'b0, 3'd1, 64'd0, 1'b1);
        check("R4", "disable cancels", last_rd, 64'd0);

        // R9 raise pulse, no pulse on lower set
        step(1'b0, 1'b1, 3'd1, 64'h0004, 1'b1);
        step(1'b0, 1'b0, 3'd0, 64'd0, 1'b0);
        check("R9", "pulse after raise", 64'(last_f == 2'd0 && irq_check), 64'd1);
        step(1'b0, 1'b1, 3'd2, 64'h0002, 1'b1);
        step(1'b0, 1'b0, 3'd0, 64'd0, 1'b0);
        check("R9", "no pulse on lower", 64'(irq_check), 64'd0);

        // R10 unmapped accesses
        step(1'b0, 1'b1, 3'd6, 64'hFFFF, 1'b1);
        check("R10", "unmapped write", 64'(last_f), 64'd3);
        step(1'b1, 1'b0, 3'd2, 64'd0, 1'b1);
        check("R10", "alias read", 64'(last_f), 64'd3);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int          op;
            logic [2:0]  a;
            logic [63:0] d;
            logic        p;
            op = int'($urandom % 8);
            a  = 3'($urandom % 8);
            p  = ($urandom % 4) != 0;
            d  = {$urandom, $urandom};
            if (a == 3'd4 && ($urandom % 2) == 0)
                d = {($urandom % 4) == 0, m_cnt + 63'($urandom % 16)};
            if (op < 4)       step(1'b0, 1'b0, a, d, p);
            else if (op == 4) step(1'b1, 1'b0, a, d, p);
            else              step(1'b0, 1'b1, a, d, p);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule